// File: doc/BRIEF.md
# Bridge Parity and System-Error Reporter

This block collects the error events of a two-sided bus bridge (a primary side facing the host and a secondary side facing the far bus). It covers two cases. The first is a data parity error reported by the target of a posted write on the bus where that write completes. The second is an assertion of the secondary system-error line. For each event it updates sticky status bits and masked interrupt-status bits. When a chain of enable bits allows it, it forwards the error upstream by pulsing the active-low primary system-error output.

A parity error is reported only if the initiating side of the write did not already flag it. Once the initiating side has flagged it, the master already knows, and nothing more is done here. The write direction selects which status bit is set: a downstream write completes on the secondary bus, and an upstream write completes on the primary bus. Each status bit has an interrupt-status twin with its own mask. The interrupt request is the OR of all interrupt-status bits. Software reads both registers through a small register port and clears bits by writing ones.

Top module: `bridge_err_reporter`

## Requirements
- R1: A parity event (`pe_valid`=1) with `pe_init_seen`=1 changes no status bit, no interrupt-status bit and leaves `pri_serr_n` high.
- R2: A parity event with `pe_init_seen`=0 and `pe_dir_up`=0 (downstream) sets status bit 0 (status register at address 0) if and only if `en_sec_par` is 1.
- R3: A parity event with `pe_init_seen`=0 and `pe_dir_up`=1 (upstream) sets status bit 1 if and only if `en_pri_par` is 1.
- R4: On the edge that sets a status bit, the interrupt-status register (address 1) sets the same bit position if that bit's mask is 0 (bit 0: `msk_sec_par`, bit 1: `msk_pri_par`, bit 2: `msk_sserr`); with the mask set it stays 0.
- R5: A reported parity event, in either direction, drives `pri_serr_n` low only when `en_sec_par`, `en_pri_par` and `en_serr` are all 1.
- R6: A `sserr_pulse` sets status bit 2 (received system error) unconditionally and drives `pri_serr_n` low when `en_serr` and `en_sec_serr` are both 1.
- R7: Status and interrupt-status bits are sticky. A write (`reg_wr`=1) to address 0 or 1 clears exactly the bits written as 1. A set on the same edge as a clear wins. Writes to other addresses change nothing.
- R8: `pri_serr_n` is low for exactly the one cycle following the clock edge that samples a qualifying event, and high otherwise.
- R9: `irq` equals the OR of the three interrupt-status bits.
- R10: Synchronous reset (`rst`=1) clears both registers and holds `pri_serr_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_valid | input | 1 | One-cycle pulse: target reported a data parity error on a posted write |
| pe_dir_up | input | 1 | Direction of that write: 1 upstream (completes on primary), 0 downstream |
| pe_init_seen | input | 1 | Initiating bus already detected a parity error for that write |
| sserr_pulse | input | 1 | One-cycle pulse: secondary system-error line asserted |
| en_sec_par | input | 1 | Secondary parity error reporting enable |
| en_pri_par | input | 1 | Primary parity error reporting enable |
| en_serr | input | 1 | Primary system-error output enable |
| en_sec_serr | input | 1 | Secondary system-error forwarding enable |
| msk_sec_par | input | 1 | Interrupt mask for the downstream parity status |
| msk_pri_par | input | 1 | Interrupt mask for the upstream parity status |
| msk_sserr | input | 1 | Interrupt mask for the received system error status |
| reg_wr | input | 1 | Register write strobe (write-1-to-clear) |
| reg_addr | input | ADDR_W | Register address: 0 status, 1 interrupt status |
| reg_wdata | input | 3 | Write data, one clear bit per status position |
| reg_rdata | output | 3 | Read data of the addressed register (0 for other addresses) |
| irq | output | 1 | Interrupt request |
| pri_serr_n | output | 1 | Active-low primary system-error pulse |

## Verification
Status and interrupt-status bits change on the same edge that samples an event. They are readable through the combinational read port in the cycle after that edge, and `irq` follows in that cycle as well. `pri_serr_n` is registered: it is low for the cycle after the sampling edge and must be high again one edge later. The bench drives each event on a falling edge, so it is held for exactly one rising edge. It samples every result at the next falling edge, then checks the release of `pri_serr_n` at the falling edge after that. The same-edge cases are driven together and read back only after the edge: a set with a clear, and a reset with pending bits.

// File: rtl/berr_pkg.sv
package berr_pkg;

    // Number of tracked error sources; bit positions below are decoded by software.
    localparam int NUM_ERR    = 3;
    localparam int BIT_SEC_DP = 0;   // downstream write, parity error on secondary
    localparam int BIT_PRI_DP = 1;   // upstream write, parity error on primary
    localparam int BIT_SSERR  = 2;   // secondary system error received

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic      valid;
        xfer_dir_e dir;
        logic      init_seen;
    } par_evt_t;

    typedef struct packed {
        logic sec_par;
        logic pri_par;
        logic serr;
        logic sec_serr;
    } ctl_en_t;

    typedef struct packed {
        logic sec_par;
        logic pri_par;
        logic sserr;
    } ctl_msk_t;

    // Next value of a write-1-to-clear sticky vector; set takes priority.
    function automatic err_vec_t w1c_next(err_vec_t cur, err_vec_t set, err_vec_t clr);
        return set | (cur & ~clr);
    endfunction

    function automatic err_vec_t mask_vec(ctl_msk_t m);
        err_vec_t v;
        v             = '0;
        v[BIT_SEC_DP] = m.sec_par;
        v[BIT_PRI_DP] = m.pri_par;
        v[BIT_SSERR]  = m.sserr;
        return v;
    endfunction

endpackage

// File: rtl/berr_event_qual.sv
module berr_event_qual
    import berr_pkg::*;
(
    input  par_evt_t evt,
    input  logic     sserr_evt,
    input  ctl_en_t  en,
    input  ctl_msk_t msk,
    output err_vec_t sts_set,
    output err_vec_t int_set,
    output logic     serr_req
);

    logic par_report;
    logic par_fwd;
    logic sserr_fwd;

    // A parity error already flagged on the initiating bus is not reported here.
    assign par_report = evt.valid & ~evt.init_seen;

    always_comb begin
        sts_set             = '0;
        sts_set[BIT_SEC_DP] = par_report & (evt.dir == DIR_DOWN) & en.sec_par;
        sts_set[BIT_PRI_DP] = par_report & (evt.dir == DIR_UP)   & en.pri_par;
        sts_set[BIT_SSERR]  = sserr_evt;
    end

    assign int_set   = sts_set & ~mask_vec(msk);

    assign par_fwd   = par_report & en.sec_par & en.pri_par & en.serr;
    assign sserr_fwd = sserr_evt & en.serr & en.sec_serr;
    assign serr_req  = par_fwd | sserr_fwd;

endmodule

// File: rtl/berr_w1c_bank.sv
module berr_w1c_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr_en && clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/berr_serr_drv.sv
module berr_serr_drv (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic serr_n
);

    // One registered low cycle per sampled request; released (high) otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            serr_n <= 1'b1;
        end else begin
            serr_n <= ~req;
        end
    end

endmodule

// File: rtl/bridge_err_reporter.sv
module bridge_err_reporter
    import berr_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pe_valid,
    input  logic               pe_dir_up,
    input  logic               pe_init_seen,
    input  logic               sserr_pulse,
    input  logic               en_sec_par,
    input  logic               en_pri_par,
    input  logic               en_serr,
    input  logic               en_sec_serr,
    input  logic               msk_sec_par,
    input  logic               msk_pri_par,
    input  logic               msk_sserr,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_ERR-1:0] reg_wdata,
    output logic [NUM_ERR-1:0] reg_rdata,
    output logic               irq,
    output logic               pri_serr_n
);

    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] INT_ADDR = ADDR_W'(1);

    par_evt_t evt;
    ctl_en_t  en;
    ctl_msk_t msk;
    err_vec_t sts_set;
    err_vec_t int_set;
    err_vec_t sts_q;
    err_vec_t int_q;
    logic     serr_req;
    logic     sts_clr_en;
    logic     int_clr_en;

    assign evt = '{valid: pe_valid, dir: xfer_dir_e'(pe_dir_up), init_seen: pe_init_seen};
    assign en  = '{sec_par: en_sec_par, pri_par: en_pri_par, serr: en_serr, sec_serr: en_sec_serr};
    assign msk = '{sec_par: msk_sec_par, pri_par: msk_pri_par, sserr: msk_sserr};

    berr_event_qual u_qual (
        .evt      (evt),
        .sserr_evt(sserr_pulse),
        .en       (en),
        .msk      (msk),
        .sts_set  (sts_set),
        .int_set  (int_set),
        .serr_req (serr_req)
    );

    assign sts_clr_en = reg_wr && (reg_addr == STS_ADDR);
    assign int_clr_en = reg_wr && (reg_addr == INT_ADDR);

    berr_w1c_bank #(.W(NUM_ERR)) u_sts (
        .clk   (clk),
        .rst   (rst),
        .set   (sts_set),
        .clr_en(sts_clr_en),
        .clr   (reg_wdata),
        .q     (sts_q)
    );

    berr_w1c_bank #(.W(NUM_ERR)) u_int (
        .clk   (clk),
        .rst   (rst),
        .set   (int_set),
        .clr_en(int_clr_en),
        .clr   (reg_wdata),
        .q     (int_q)
    );

    berr_serr_drv u_serr (
        .clk   (clk),
        .rst   (rst),
        .req   (serr_req),
        .serr_n(pri_serr_n)
    );

    always_comb begin
        unique case (reg_addr)
            STS_ADDR: reg_rdata = sts_q;
            INT_ADDR: reg_rdata = int_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |int_q;

endmodule

// File: rtl/berr_checker.sv
module berr_checker
    import berr_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pe_valid,
    input logic              pe_dir_up,
    input logic              pe_init_seen,
    input logic              sserr_pulse,
    input logic              en_sec_par,
    input logic              en_pri_par,
    input logic              en_serr,
    input logic              en_sec_serr,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input err_vec_t          reg_wdata,
    input err_vec_t          sts_q,
    input err_vec_t          int_q,
    input logic              pri_serr_n
);

    err_vec_t sts_clr;
    logic     ok_par;
    logic     ok_ss;

    assign sts_clr = (reg_wr && reg_addr == '0) ? reg_wdata : '0;
    assign ok_par  = pe_valid & ~pe_init_seen & en_sec_par & en_pri_par & en_serr;
    assign ok_ss   = sserr_pulse & en_serr & en_sec_serr;

    AST_SUPPRESS_INIT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pe_valid && pe_init_seen && !sserr_pulse)) |-> pri_serr_n); // R1

    AST_SERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        !pri_serr_n |-> $past(ok_par || ok_ss)); // R5

    AST_SSERR_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ok_ss)) |-> (!pri_serr_n && sts_q[BIT_SSERR])); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(sts_q) & ~$past(sts_clr)) & ~sts_q) == '0)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pe_valid && !pe_init_seen && !pe_dir_up && en_sec_par
                              && sts_clr[BIT_SEC_DP])) |-> sts_q[BIT_SEC_DP]); // R7

    AST_INT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        ((int_q & ~$past(int_q) & ~sts_q) == '0)); // R4

endmodule

bind bridge_err_reporter berr_checker #(.ADDR_W(ADDR_W)) i_berr_checker (
    .clk         (clk),
    .rst         (rst),
    .pe_valid    (pe_valid),
    .pe_dir_up   (pe_dir_up),
    .pe_init_seen(pe_init_seen),
    .sserr_pulse (sserr_pulse),
    .en_sec_par  (en_sec_par),
    .en_pri_par  (en_pri_par),
    .en_serr     (en_serr),
    .en_sec_serr (en_sec_serr),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .sts_q       (sts_q),
    .int_q       (int_q),
    .pri_serr_n  (pri_serr_n)
);

// File: tb/test_bridge_err_reporter.sv
`timescale 1ns/1ps
module test_bridge_err_reporter;

    localparam int ADDR_W = 2;
    localparam int NV     = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              pe_valid, pe_dir_up, pe_init_seen, sserr_pulse;
    logic              en_sec_par, en_pri_par, en_serr, en_sec_serr;
    logic              msk_sec_par, msk_pri_par, msk_sserr;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [2:0]        reg_wdata;
    logic [2:0]        reg_rdata;
    logic              irq;
    logic              pri_serr_n;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    bridge_err_reporter #(.ADDR_W(ADDR_W)) i_bridge_err_reporter (.*);

    // Row: {ev[3:0]=valid,up,init,sserr}{en[3:0]=sec_par,pri_par,serr,sec_serr}
    //      {msk[2:0]=sec,pri,sserr}{serr_low}{status[2:0]}{int_status[2:0]}
    localparam logic [17:0] VEC [NV] = '{
        18'b1000_1111_000_1_001_001,  // R2 R5 downstream reported
        18'b1010_1111_000_0_000_000,  // R1 downstream, initiator saw it
        18'b1000_0111_000_0_000_000,  // R2 secondary reporting off
        18'b1000_1111_100_1_001_000,  // R4 masked
        18'b1100_1111_000_1_010_010,  // R3 R5 upstream reported
        18'b1100_1011_000_0_000_000,  // R3 primary reporting off
        18'b1100_1101_000_0_010_010,  // R5 serr enable off
        18'b1100_1111_010_1_010_000,  // R4 masked
        18'b0001_0011_000_1_100_100,  // R6 forwarded
        18'b0001_0010_000_0_100_100,  // R6 secondary forward off
        18'b0001_0011_001_1_100_000,  // R4 R6 masked
        18'b1100_0110_000_0_010_010,  // R5 secondary enable missing
        18'b1000_1010_000_0_001_001,  // R5 primary enable missing
        18'b1001_1111_000_1_101_101,  // R6 both events
        18'b0000_1111_000_0_000_000,  // no event
        18'b1110_1111_000_0_000_000   // R1 upstream, initiator saw it
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [2:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [2:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_ctl(input logic [3:0] en, input logic [2:0] msk);
        {en_sec_par, en_pri_par, en_serr, en_sec_serr} = en;
        {msk_sec_par, msk_pri_par, msk_sserr} = msk;
    endtask

    // Drives an event for exactly one rising edge; returns at the next falling edge.
    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {pe_valid, pe_dir_up, pe_init_seen, sserr_pulse} = ev;
        @(negedge clk);
        {pe_valid, pe_dir_up, pe_init_seen, sserr_pulse} = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [2:0] v;
        rst = 1'b1;
        {pe_valid, pe_dir_up, pe_init_seen, sserr_pulse} = '0;
        set_ctl(4'b0000, 3'b000);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 serr released", int'(pri_serr_n), 1);
        rd(0, v); chk("R10 status", int'(v), 0);
        rd(1, v); chk("R10 int status", int'(v), 0);
        chk("R10 irq", int'(irq), 0);

        // Table of event/enable/mask combinations
        for (int i = 0; i < NV; i++) begin
            logic [17:0] row;
            row = VEC[i];
            wr(0, 3'b111);
            wr(1, 3'b111);
            set_ctl(row[13:10], row[9:7]);
            pulse(row[17:14]);
            chk($sformatf("R5 R8 serr low row %0d", i), int'(pri_serr_n), int'(!row[6]));
            rd(0, v); chk($sformatf("R2 R3 R6 status row %0d", i), int'(v), int'(row[5:3]));
            rd(1, v); chk($sformatf("R4 int status row %0d", i), int'(v), int'(row[2:0]));
            chk($sformatf("R9 irq row %0d", i), int'(irq), int'(|row[2:0]));
            @(negedge clk);
            chk($sformatf("R8 serr release row %0d", i), int'(pri_serr_n), 1);
        end

        // R7 sticky hold and selective clear
        wr(0, 3'b111); wr(1, 3'b111);
        set_ctl(4'b1111, 3'b000);
        pulse(4'b1000);
        repeat (4) @(negedge clk);
        rd(0, v); chk("R7 sticky after idle", int'(v), 1);
        wr(0, 3'b010);
        rd(0, v); chk("R7 other bit clear keeps bit", int'(v), 1);
        wr(2, 3'b111);
        rd(0, v); chk("R7 unused address ignored", int'(v), 1);
        rd(1, v); chk("R7 unused address int", int'(v), 1);
        wr(0, 3'b001);
        rd(0, v); chk("R7 status cleared", int'(v), 0);
        rd(1, v); chk("R7 int unaffected by status clear", int'(v), 1);
        chk("R9 irq still high", int'(irq), 1);
        wr(1, 3'b001);
        chk("R9 irq low after int clear", int'(irq), 0);

        // R7 set wins over clear on the same edge
        @(negedge clk);
        {pe_valid, pe_dir_up, pe_init_seen, sserr_pulse} = 4'b1000;
        reg_wr = 1'b1; reg_addr = '0; reg_wdata = 3'b001;
        @(negedge clk);
        {pe_valid, pe_dir_up, pe_init_seen, sserr_pulse} = '0;
        reg_wr = 1'b0; reg_wdata = '0;
        rd(0, v); chk("R7 set wins", int'(v), 1);

        // R8 back-to-back events give two low cycles, then release
        @(negedge clk);
        sserr_pulse = 1'b1;
        @(negedge clk);
        chk("R8 first low", int'(pri_serr_n), 0);
        @(negedge clk);
        sserr_pulse = 1'b0;
        chk("R8 second low", int'(pri_serr_n), 0);
        @(negedge clk);
        chk("R8 released", int'(pri_serr_n), 1);

        // R10 reset clears pending bits
        pulse(4'b1100);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(0, v); chk("R10 status cleared", int'(v), 0);
        rd(1, v); chk("R10 int cleared", int'(v), 0);
        chk("R10 serr high", int'(pri_serr_n), 1);

        finish_run();
    end

endmodule